// File: doc/BRIEF.md
# Serial Command Shifter with Delayed Echo Output

The block receives 16-bit command words over a three-wire serial link: an active-low select, a serial clock and a data line. Words arrive most significant bit first. The serial pins are oversampled in the system clock domain through synchronizers. Each rising serial clock edge seen while the select is low shifts one bit into a 16-bit register. When the select returns high, the block registers the captured word and raises a one-cycle execute strobe for the command decoder downstream.

The serial output echoes the input stream delayed by sixteen serial clocks. This lets several devices share one select and be chained, each passing on the word it has already received. A phase input from the decoder chooses whether the output is launched on the falling serial edge (the reset default) or on the rising edge. The choice is latched when the select falls, so it governs a whole transfer. The output is always driven. While the select is high, it holds its last value.

Top module: `serial_echo_frontend`

## Requirements
- R1: During and right after reset, `sdo`, `cmd_exec` and `cmd_word` are all zero, the phase is falling-edge launch (0), and the shift register holds zero, so the first sixteen echoed bits are 0.
- R2: While `cs_n` is low, each rising `sclk` edge shifts `sdi` into the shift register. After the select rises, `cmd_word` bit 15 holds the first bit of the transfer and bit 0 holds the last.
- R3: Each rising edge of `cs_n` produces exactly one `cmd_exec` pulse, one system clock wide.
- R4: With phase 1, the k-th rising `sclk` edge of the stream sets `sdo` to the bit received at edge k-16. Between edges the output does not change.
- R5: With phase 0, the falling `sclk` edge after rising edge k sets `sdo` to the bit received at edge k-15. The falling edge of `cs_n` sets `sdo` to the oldest bit held in the shift register.
- R6: `phase_sel` is sampled only when `cs_n` falls. A change during a transfer takes effect from the next transfer.
- R7: While `cs_n` is high, `sclk` and `sdi` activity is ignored: `sdo` holds, the shift register and the echo stream are unchanged, and no strobe is issued.
- R8: `cmd_word` changes only together with `cmd_exec` and holds between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| phase_sel | input | 1 | Output launch edge for the next transfer: 0 falling, 1 rising |
| sdo | output | 1 | Serial data out, 16-clock delayed echo |
| cmd_word | output | WORD_W | Last captured command word |
| cmd_exec | output | 1 | One-cycle strobe when a word is ready |

## Verification
A corrupted or slipped shift register shows up on `sdo` sixteen serial clocks after the damaged bit, which is within the next transfer. It also shows up at once in `cmd_word` at the following strobe. A wrong latched phase appears at the first falling serial edge of a transfer: the output advances half a serial clock early or late. A select edge that is missed or seen twice shows up within a few system clocks, as a missing or extra strobe.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic {
    PH_FALL = 1'b0,
    PH_RISE = 1'b1
  } phase_e;

  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_SYNC_N = 2;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sfe_edges.sv
module sfe_edges (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic sclk_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise
);
  logic cs_p;
  logic sclk_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p   <= 1'b1;
      sclk_p <= 1'b0;
    end else begin
      cs_p   <= cs_s;
      sclk_p <= sclk_s;
    end
  end

  assign sclk_rise = ~cs_s & sclk_s & ~sclk_p;
  assign sclk_fall = ~cs_s & ~sclk_s & sclk_p;
  assign cs_fall   = ~cs_s & cs_p;
  assign cs_rise   = cs_s & ~cs_p;
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
  import sfe_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              phase_in,
  output logic              sdo,
  output logic [WORD_W-1:0] shreg,
  output phase_e            mode_q,
  output logic [WORD_W-1:0] word_q,
  output logic              exec_q
);
  localparam int unsigned MSB = WORD_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      sdo    <= 1'b0;
      mode_q <= PH_FALL;
      word_q <= '0;
      exec_q <= 1'b0;
    end else begin
      exec_q <= cs_rise;
      if (cs_rise) word_q <= shreg;
      if (cs_fall) begin
        mode_q <= phase_e'(phase_in);
        if (phase_e'(phase_in) == PH_FALL) sdo <= shreg[MSB];
      end
      if (sclk_rise) begin
        shreg <= {shreg[MSB-1:0], sdi_s};
        if (mode_q == PH_RISE) sdo <= shreg[MSB];
      end
      if (sclk_fall && mode_q == PH_FALL) sdo <= shreg[MSB];
    end
  end
endmodule

// File: rtl/serial_echo_frontend.sv
module serial_echo_frontend
  import sfe_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              phase_sel,
  output logic              sdo,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_exec
);
  logic [2:0]        pins_s;
  logic              cs_s, sclk_s, sdi_s;
  logic              sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [WORD_W-1:0] shreg;
  phase_e            mode_act;

  sfe_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sclk, sdi}),
    .q   (pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  sfe_edges u_edges (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (cs_s),
    .sclk_s    (sclk_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise)
  );

  sfe_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sdi_s     (sdi_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .phase_in  (phase_sel),
    .sdo       (sdo),
    .shreg     (shreg),
    .mode_q    (mode_act),
    .word_q    (cmd_word),
    .exec_q    (cmd_exec)
  );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_s,
  input logic              sclk_rise,
  input logic              cs_fall,
  input logic              mode_act,
  input logic [WORD_W-1:0] shreg,
  input logic              sdo,
  input logic [WORD_W-1:0] cmd_word,
  input logic              cmd_exec
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (sdo == 1'b0 && cmd_exec == 1'b0 && cmd_word == '0 && shreg == '0));

  a_r3_exec_single: assert property (@(posedge clk) disable iff (rst)
    cmd_exec |=> !cmd_exec);

  a_r8_word_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_exec |-> $stable(cmd_word));

  a_r7_sdo_hold: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s)) |-> $stable(sdo));

  a_r2_shift_only_on_rise: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(shreg));

  a_r6_phase_latched: assert property (@(posedge clk) disable iff (rst)
    !cs_fall |=> $stable(mode_act));
endmodule

bind serial_echo_frontend sfe_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_s      (cs_s),
  .sclk_rise (sclk_rise),
  .cs_fall   (cs_fall),
  .mode_act  (mode_act),
  .shreg     (shreg),
  .sdo       (sdo),
  .cmd_word  (cmd_word),
  .cmd_exec  (cmd_exec)
);

// File: tb/serial_echo_frontend_bench.sv
module serial_echo_frontend_bench;
  localparam int W    = 16;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, phase_sel = 1'b0;
  logic sdo, cmd_exec;
  logic [W-1:0] cmd_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit           hist[$];
  logic [W-1:0] expq[$];
  logic         exp_sdo = 1'b0;
  logic [W-1:0] last_word = '0;

  always #5 clk = ~clk;

  serial_echo_frontend #(.WORD_W(W)) u_serial_echo_frontend (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .phase_sel(phase_sel), .sdo(sdo), .cmd_word(cmd_word), .cmd_exec(cmd_exec)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: pops expected words as strobes appear (R2, R3, R7, R8)
  logic prev_exec = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_exec) begin
        if (prev_exec) check("R3 strobe width", 1, 0);
        if (expq.size() == 0) check("R7 unexpected strobe", 1, 0);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          check("R2 captured word", cmd_word, e);
          last_word = e;
        end
      end else if (cmd_word !== last_word) begin
        check("R8 word hold", cmd_word, last_word);
      end
      prev_exec = cmd_exec;
    end
  end

  task automatic xfer(input logic [W-1:0] w, input logic mode, input bit flip);
    int idx;
    phase_sel = mode;
    cs_n = 1'b0;
    tick(HALF);
    if (mode == 1'b0) exp_sdo = hist[hist.size()-16];
    check(mode ? "R4 select fall hold" : "R5 select fall launch", sdo, exp_sdo);
    for (int j = 0; j < W; j++) begin
      sdi = w[W-1-j];
      if (flip && j == 8) phase_sel = ~mode;
      tick(HALF);
      sclk = 1'b1;
      hist.push_back(w[W-1-j]);
      idx = hist.size() - 1;
      tick(HALF);
      if (mode == 1'b1) exp_sdo = hist[idx-16];
      check(mode ? "R4 rise launch" : "R5 hold after rise", sdo, exp_sdo);
      sclk = 1'b0;
      tick(HALF);
      if (mode == 1'b0) exp_sdo = hist[idx-15];
      check(flip ? "R6 phase kept mid transfer" : (mode ? "R4 hold after fall" : "R5 fall launch"),
            sdo, exp_sdo);
    end
    expq.push_back(w);
    cs_n = 1'b1;
    tick(3 * HALF);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < W; i++) hist.push_back(1'b0);
    tick(4);
    check("R1 sdo reset", sdo, 0);
    check("R1 exec reset", cmd_exec, 0);
    check("R1 word reset", cmd_word, 0);
    rst = 1'b0;
    tick(4);
    check("R1 sdo after reset", sdo, 0);

    xfer(16'hA5C3, 1'b0, 1'b0);   // R1 zero echo, R2, R5
    xfer(16'h1234, 1'b0, 1'b0);   // R5 echo of previous word
    xfer(16'hFFFF, 1'b1, 1'b0);   // R4
    xfer(16'h0F0F, 1'b1, 1'b1);   // R6 flip to 0 mid transfer ignored
    xfer(16'h8001, 1'b0, 1'b1);   // R6 flip to 1 mid transfer ignored

    // R7: activity with select high is ignored
    for (int k = 0; k < 5; k++) begin
      sdi = k[0];
      sclk = 1'b1;
      tick(HALF);
      check("R7 sdo holds with select high", sdo, exp_sdo);
      sclk = 1'b0;
      tick(HALF);
      check("R7 sdo holds with select high", sdo, exp_sdo);
    end
    check("R7 no strobe pending", expq.size(), 0);

    xfer(16'h7E81, 1'b0, 1'b0);   // R7 echo continues unaffected
    xfer(16'h0000, 1'b1, 1'b0);
    tick(10);
    check("R3 one strobe per select rise", expq.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule